// File: doc/BRIEF.md
# Programmable Dot-Clock Panel Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel-position signals for a parallel RGB panel that is clocked by a dot clock. It also produces one-cycle strobes that mark the start of each line and each frame. All timing comes from input fields. The horizontal fields are the total line period, the hsync pulse width, a wait count and a valid-pixel count. The vertical fields are the total frame length in lines, the vsync width in lines, a line wait count and a valid-line count. Each wait count covers the sync pulse plus the back porch, so active data starts once the wait has elapsed.

The timing fields and the three polarity selects are captured into a shadow copy at frame boundaries only, and also continuously while the sync outputs are disabled. A write in the middle of a frame therefore takes effect on the next frame and cannot tear the frame in progress. The block keeps a pair of frame-buffer start addresses, current and next. The next address is copied to the current one at the frame boundary, so the frame that is being scanned out always uses a stable address.

Scanning is controlled by two inputs: a sync-output enable and a run request. The sync enable starts the counters. A run request is accepted only while sync is enabled, and data enable is produced only while run is active. After the run request is withdrawn, run stays active until the pixel path reports that its buffered data is drained. A version parameter sets the width of the hsync pulse-width field: 8 bits when the parameter is 3, and 14 bits otherwise.

Top module: `lcd_dotclk_timing`

## Requirements
- R1: While reset is high, and in the first cycle after it, the line and frame counters are 0, run is inactive, the current address is 0 and all polarity selects read as 0. As a result hsync, vsync and de are all 1, which is the inactive level for polarity 0.
- R2: While sync is enabled, the pixel counter h steps 0, 1, ..., period−1 and then wraps to 0. The raw hsync is active while h is less than the hsync width.
- R3: The line counter v advances when h wraps and wraps to 0 after the frame length minus 1. The raw vsync is active while v is less than the vsync width, which is counted in lines.
- R4: The raw de is active only when run is active, sync is enabled, h is in the range [h_wait, h_wait+h_valid) and v is in the range [v_wait, v_wait+v_valid).
- R5: While raw de is active, pix_x equals h−h_wait and pix_y equals v−v_wait. At all other times both are 0.
- R6: line_start is 1 in every cycle where sync is enabled and h is 0. frame_start is 1 when, in addition, v is 0.
- R7: cur_addr takes the value of next_addr only at the clock edge that ends a frame, or at any edge while sync is disabled. Otherwise it holds its value.
- R8: Run becomes active one cycle after run_req is seen with sync_en high. Once run_req is low, run stays active until pix_drained is seen high, and then it clears on the next edge.
- R9: While sync_en is low, hsync, vsync and de are at their inactive levels, line_start and frame_start are 0, and the counters return to 0 on the next edge.
- R10: Timing fields and polarity selects take effect only from the frame boundary (or while sync is disabled). A change during a frame leaves that frame unchanged.
- R11: Each of hsync, vsync and de is active-high when its polarity select is 1 and active-low when the select is 0.
- R12: A line period of 0 or 1 makes h wrap every cycle, so line_start is 1 in every enabled cycle. A frame length of 0 or 1 makes every line the last line of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_en | input | 1 | Enables the sync outputs and the counters |
| run_req | input | 1 | Request to start or continue driving pixel data |
| pix_drained | input | 1 | Pixel path reports that its buffered data is exhausted |
| h_period | input | 18 | Line length in dot clocks |
| h_pulse | input | HPW_W (8 or 14) | Hsync pulse width in dot clocks |
| h_wait | input | 12 | Hsync width plus back porch |
| h_valid | input | 18 | Active pixels per line |
| v_period | input | 16 | Frame length in lines |
| v_pulse | input | 18 | Vsync pulse width in lines |
| v_wait | input | 16 | Vsync width plus upper porch, in lines |
| v_valid | input | 16 | Active lines per frame |
| hs_pol | input | 1 | 1 = hsync active high |
| vs_pol | input | 1 | 1 = vsync active high |
| de_pol | input | 1 | 1 = de active high |
| next_addr | input | ADDR_W | Start address of the next frame buffer |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable, polarity applied |
| line_start | output | 1 | One-cycle strobe at the start of each line |
| frame_start | output | 1 | One-cycle strobe at the start of each frame |
| pix_x | output | 18 | Active pixel column |
| pix_y | output | 16 | Active line |
| cur_addr | output | ADDR_W | Buffer address used by the current frame |
| run_active | output | 1 | Run state, including the drain phase |

## Verification
A counter that wraps at the wrong point shows up at the ports within one line: line_start lands in the wrong cycle, and the hsync width or the de window shifts. A vertical error shows up at the next frame_start. A shadow register or buffer address that loads at the wrong edge changes cur_addr or a sync width in the middle of a frame, and this is visible in the very next cycle. The bench therefore compares every output against an independent cycle model in every cycle. It uses random configurations that change mid-frame, so that any early or late capture of a field diverges immediately.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    localparam int H_W     = 18;
    localparam int HWAIT_W = 12;
    localparam int V_W     = 16;
    localparam int VPW_W   = 18;
    localparam int HPW_MAX = 14;

    function automatic int hpw_bits(input int version);
        return (version == 3) ? 8 : HPW_MAX;
    endfunction

    typedef struct packed {
        logic [H_W-1:0]     h_period;
        logic [HPW_MAX-1:0] h_pulse;
        logic [HWAIT_W-1:0] h_wait;
        logic [H_W-1:0]     h_valid;
        logic [V_W-1:0]     v_period;
        logic [VPW_W-1:0]   v_pulse;
        logic [V_W-1:0]     v_wait;
        logic [V_W-1:0]     v_valid;
        logic               hs_pol;
        logic               vs_pol;
        logic               de_pol;
    } timing_t;
endpackage

// File: rtl/lcdt_shadow.sv
module lcdt_shadow
    import lcdt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  timing_t           cfg_in,
    input  logic [ADDR_W-1:0] next_addr,
    output timing_t           cfg_q,
    output logic [ADDR_W-1:0] cur_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            cur_addr <= '0;
        end else if (load) begin
            cfg_q    <= cfg_in;
            cur_addr <= next_addr;
        end
    end

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cur_addr));
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q));
endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan
    import lcdt_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [H_W-1:0] h_period,
    input  logic [V_W-1:0] v_period,
    output logic [H_W-1:0] hcnt,
    output logic [V_W-1:0] vcnt,
    output logic           frame_end
);
    logic h_last, v_last;

    assign h_last    = (32'(hcnt) + 32'd1) >= 32'(h_period);
    assign v_last    = (32'(vcnt) + 32'd1) >= 32'(v_period);
    assign frame_end = en && h_last && v_last;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (h_last) begin
            hcnt <= '0;
            vcnt <= v_last ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    assert_h_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (hcnt == '0) || (32'(hcnt) < 32'(h_period)));
    assert_v_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (vcnt == '0) || (32'(vcnt) < 32'(v_period)));
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (hcnt == '0 && vcnt == '0));
endmodule

// File: rtl/lcdt_run_ctl.sv
module lcdt_run_ctl (
    input  logic clk,
    input  logic rst,
    input  logic sync_en,
    input  logic run_req,
    input  logic pix_drained,
    output logic run_active
);
    always_ff @(posedge clk) begin
        if (rst)
            run_active <= 1'b0;
        else if (run_req && sync_en)
            run_active <= 1'b1;
        else if (!run_req && pix_drained)
            run_active <= 1'b0;
    end

    assert_run_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(run_active) |-> $past(run_req && sync_en));
    assert_run_drain_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(run_active) |-> $past(!run_req && pix_drained));
endmodule

// File: rtl/lcd_dotclk_timing.sv
module lcd_dotclk_timing
    import lcdt_pkg::*;
#(
    parameter int VERSION = 4,
    parameter int ADDR_W  = 32,
    localparam int HPW_W  = hpw_bits(VERSION)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_en,
    input  logic               run_req,
    input  logic               pix_drained,
    input  logic [H_W-1:0]     h_period,
    input  logic [HPW_W-1:0]   h_pulse,
    input  logic [HWAIT_W-1:0] h_wait,
    input  logic [H_W-1:0]     h_valid,
    input  logic [V_W-1:0]     v_period,
    input  logic [VPW_W-1:0]   v_pulse,
    input  logic [V_W-1:0]     v_wait,
    input  logic [V_W-1:0]     v_valid,
    input  logic               hs_pol,
    input  logic               vs_pol,
    input  logic               de_pol,
    input  logic [ADDR_W-1:0]  next_addr,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic               line_start,
    output logic               frame_start,
    output logic [H_W-1:0]     pix_x,
    output logic [V_W-1:0]     pix_y,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic               run_active
);
    timing_t        cfg_in, cfg;
    logic [H_W-1:0] hcnt;
    logic [V_W-1:0] vcnt;
    logic           frame_end, load;
    logic           hs_raw, vs_raw, de_raw, in_h, in_v;

    always_comb begin
        cfg_in          = '0;
        cfg_in.h_period = h_period;
        cfg_in.h_pulse  = HPW_MAX'(h_pulse);
        cfg_in.h_wait   = h_wait;
        cfg_in.h_valid  = h_valid;
        cfg_in.v_period = v_period;
        cfg_in.v_pulse  = v_pulse;
        cfg_in.v_wait   = v_wait;
        cfg_in.v_valid  = v_valid;
        cfg_in.hs_pol   = hs_pol;
        cfg_in.vs_pol   = vs_pol;
        cfg_in.de_pol   = de_pol;
    end

    assign load = !sync_en || frame_end;

    lcdt_shadow #(.ADDR_W(ADDR_W)) u_shadow (
        .clk(clk), .rst(rst), .load(load), .cfg_in(cfg_in),
        .next_addr(next_addr), .cfg_q(cfg), .cur_addr(cur_addr)
    );

    lcdt_scan u_scan (
        .clk(clk), .rst(rst), .en(sync_en),
        .h_period(cfg.h_period), .v_period(cfg.v_period),
        .hcnt(hcnt), .vcnt(vcnt), .frame_end(frame_end)
    );

    lcdt_run_ctl u_run (
        .clk(clk), .rst(rst), .sync_en(sync_en), .run_req(run_req),
        .pix_drained(pix_drained), .run_active(run_active)
    );

    assign in_h = (32'(hcnt) >= 32'(cfg.h_wait)) &&
                  (32'(hcnt) <  32'(cfg.h_wait) + 32'(cfg.h_valid));
    assign in_v = (32'(vcnt) >= 32'(cfg.v_wait)) &&
                  (32'(vcnt) <  32'(cfg.v_wait) + 32'(cfg.v_valid));

    assign hs_raw = sync_en && (32'(hcnt) < 32'(cfg.h_pulse));
    assign vs_raw = sync_en && (32'(vcnt) < 32'(cfg.v_pulse));
    assign de_raw = sync_en && run_active && in_h && in_v;

    assign hsync = cfg.hs_pol ? hs_raw : !hs_raw;
    assign vsync = cfg.vs_pol ? vs_raw : !vs_raw;
    assign de    = cfg.de_pol ? de_raw : !de_raw;

    assign line_start  = sync_en && (hcnt == '0);
    assign frame_start = line_start && (vcnt == '0);

    assign pix_x = de_raw ? hcnt - H_W'(cfg.h_wait) : '0;
    assign pix_y = de_raw ? vcnt - cfg.v_wait : '0;

    assert_fs_follows_end_R6: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (frame_start || !sync_en));
    assert_de_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
        de_raw |-> !frame_start || (cfg.h_wait == '0 && cfg.v_wait == '0));
endmodule

// File: tb/tb_lcd_dotclk_timing.sv
module tb_lcd_dotclk_timing;
    import lcdt_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, sync_en, run_req, pix_drained;
    logic [H_W-1:0] h_period, h_valid;
    logic [HPW_MAX-1:0] h_pulse;
    logic [HWAIT_W-1:0] h_wait;
    logic [V_W-1:0] v_period, v_wait, v_valid;
    logic [VPW_W-1:0] v_pulse;
    logic hs_pol, vs_pol, de_pol;
    logic [31:0] next_addr;
    logic hsync, vsync, de, line_start, frame_start, run_active;
    logic [H_W-1:0] pix_x;
    logic [V_W-1:0] pix_y;
    logic [31:0] cur_addr;

    lcd_dotclk_timing dut (
        .clk(clk), .rst(rst), .sync_en(sync_en), .run_req(run_req),
        .pix_drained(pix_drained), .h_period(h_period), .h_pulse(h_pulse),
        .h_wait(h_wait), .h_valid(h_valid), .v_period(v_period),
        .v_pulse(v_pulse), .v_wait(v_wait), .v_valid(v_valid),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .de_pol(de_pol),
        .next_addr(next_addr), .hsync(hsync), .vsync(vsync), .de(de),
        .line_start(line_start), .frame_start(frame_start), .pix_x(pix_x),
        .pix_y(pix_y), .cur_addr(cur_addr), .run_active(run_active)
    );

    int errors = 0;
    int checks = 0;

    // independent cycle model
    int unsigned m_hc, m_vc, m_cur;
    int unsigned c_hper, c_hpw, c_hwait, c_hval, c_vper, c_vpw, c_vwait, c_vval;
    bit c_hsp, c_vsp, c_dep, m_run;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        bit en, hs, vs, d;
        int unsigned ex, ey;
        #1;
        en = sync_en;
        hs = en && (m_hc < c_hpw);
        vs = en && (m_vc < c_vpw);
        d  = en && m_run && (m_hc >= c_hwait) && (m_hc < c_hwait + c_hval)
                 && (m_vc >= c_vwait) && (m_vc < c_vwait + c_vval);
        ex = d ? m_hc - c_hwait : 0;
        ey = d ? m_vc - c_vwait : 0;
        check("R2/R11 hsync", 64'(hsync), 64'(c_hsp ? hs : !hs));
        check("R3/R11 vsync", 64'(vsync), 64'(c_vsp ? vs : !vs));
        check("R4/R11 de", 64'(de), 64'(c_dep ? d : !d));
        check("R5 pix_x", 64'(pix_x), 64'(ex));
        check("R5 pix_y", 64'(pix_y), 64'(ey));
        check("R6 line_start", 64'(line_start), 64'(en && m_hc == 0));
        check("R6 frame_start", 64'(frame_start), 64'(en && m_hc == 0 && m_vc == 0));
        check("R7 cur_addr", 64'(cur_addr), 64'(m_cur));
        check("R8 run_active", 64'(run_active), 64'(m_run));
    endtask

    task automatic model_update();
        bit hl, vl, load;
        if (rst) begin
            m_hc = 0; m_vc = 0; m_run = 0; m_cur = 0;
            c_hper = 0; c_hpw = 0; c_hwait = 0; c_hval = 0;
            c_vper = 0; c_vpw = 0; c_vwait = 0; c_vval = 0;
            c_hsp = 0; c_vsp = 0; c_dep = 0;
            return;
        end
        hl = (m_hc + 1) >= c_hper;
        vl = (m_vc + 1) >= c_vper;
        load = !sync_en || (hl && vl);
        if (run_req && sync_en) m_run = 1;
        else if (!run_req && pix_drained) m_run = 0;
        if (!sync_en) begin
            m_hc = 0; m_vc = 0;
        end else if (hl) begin
            m_hc = 0; m_vc = vl ? 0 : m_vc + 1;
        end else m_hc = m_hc + 1;
        if (load) begin
            c_hper = h_period; c_hpw = h_pulse; c_hwait = h_wait; c_hval = h_valid;
            c_vper = v_period; c_vpw = v_pulse; c_vwait = v_wait; c_vval = v_valid;
            c_hsp = hs_pol; c_vsp = vs_pol; c_dep = de_pol; m_cur = next_addr;
        end
    endtask

    task automatic tick();
        check_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic rand_cfg();
        h_period = 18'($urandom_range(0, 24));
        h_pulse  = 14'($urandom_range(0, 6));
        h_wait   = 12'($urandom_range(0, 8));
        h_valid  = 18'($urandom_range(0, 12));
        v_period = 16'($urandom_range(0, 8));
        v_pulse  = 18'($urandom_range(0, 3));
        v_wait   = 16'($urandom_range(0, 3));
        v_valid  = 16'($urandom_range(0, 5));
        hs_pol = 1'($urandom); vs_pol = 1'($urandom); de_pol = 1'($urandom);
    endtask

    task automatic set_cfg(input int hp, input int hw, input int hwt, input int hv,
                           input int vp, input int vw, input int vwt, input int vv);
        h_period = 18'(hp); h_pulse = 14'(hw); h_wait = 12'(hwt); h_valid = 18'(hv);
        v_period = 16'(vp); v_pulse = 18'(vw); v_wait = 16'(vwt); v_valid = 16'(vv);
        hs_pol = 1; vs_pol = 1; de_pol = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        rst = 1; sync_en = 0; run_req = 0; pix_drained = 0; next_addr = 32'hA000_0000;
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
        hs_pol = 0; vs_pol = 0; de_pol = 0;
        @(negedge clk);
        model_update();
        repeat (3) tick();
        // R1: reset state at the ports
        #1;
        check("R1 hsync", 64'(hsync), 64'd1);
        check("R1 vsync", 64'(vsync), 64'd1);
        check("R1 de", 64'(de), 64'd1);
        check("R1 cur_addr", 64'(cur_addr), 64'd0);
        check("R1 run_active", 64'(run_active), 64'd0);
        rst = 0;
        tick();

        // directed: known frame, sync enabled then run
        set_cfg(10, 2, 3, 5, 6, 1, 2, 3);
        next_addr = 32'h1000;
        tick();
        sync_en = 1;
        repeat (5) tick();
        run_req = 1;
        for (int i = 0; i < 150; i++) begin
            if (i == 17) next_addr = 32'h2000;   // R7: mid-frame write
            if (i == 23) h_pulse = 14'd4;         // R10: mid-frame change
            tick();
        end
        // R8: drop run request, hold drain off, then drain
        run_req = 0; pix_drained = 0;
        repeat (20) tick();
        pix_drained = 1;
        repeat (4) tick();
        // R9: disable sync mid-frame
        run_req = 1;
        repeat (13) tick();
        sync_en = 0;
        repeat (6) tick();
        sync_en = 1;

        // R12: degenerate periods
        set_cfg(1, 1, 0, 1, 1, 1, 0, 1);
        sync_en = 0; tick(); sync_en = 1;
        for (int i = 0; i < 6; i++) begin
            #1 check("R12 line_start every cycle", 64'(line_start), 64'd1);
            check("R12 frame_start every cycle", 64'(frame_start), 64'd1);
            tick();
        end
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (8) tick();

        // random rounds
        for (int r = 0; r < 40; r++) begin
            rand_cfg();
            for (int i = 0; i < 120; i++) begin
                if ($urandom_range(0, 9) == 0) rand_cfg();
                if ($urandom_range(0, 3) == 0) next_addr = $urandom;
                if ($urandom_range(0, 19) == 0) run_req = !run_req;
                pix_drained = 1'($urandom);
                if ($urandom_range(0, 39) == 0) sync_en = !sync_en;
                tick();
            end
            sync_en = 1;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule